// File: doc/BRIEF.md
# Period and Lag Phase Calculator

This block measures the phase relation between two squared (logic-level) waveforms of the same frequency: a reference and a secondary signal. A single timer is shared between two measurements made one after the other. First it times the reference period T, as the number of clocks between two successive reference rising edges. It then restarts on a later reference rising edge and counts up to the first secondary rising edge, which gives the lag tl. A sequential restoring divider turns the two counts into a phase in tenths of a degree, floor(3600·tl/T). The three results are then published together with a one-cycle valid strobe.

A free-running interval counter starts a new measurement cycle every `INTERVAL` clocks, for example 500 ms at the system clock. Both inputs pass through identical synchronizers and edge detectors, so their fixed latency cancels in both counts. If an awaited edge never arrives before the timer reaches all-ones, the cycle is abandoned. An error strobe is raised and the published results are left as they were.

States: `ST_IDLE` waits for the interval tick. It moves to `ST_CLEAR`, which zeroes the timer, and then to `ST_WAIT_PER`, which waits for the first reference edge. On that edge it moves to `ST_RUN_PER`, which times until the next reference edge. The FSM then enters `ST_WAIT_LAG`, which waits for the next reference edge. From there it goes to `ST_RUN_LAG`, or straight to `ST_DIVIDE` when a secondary edge arrives in the same clock. `ST_RUN_LAG` goes to `ST_DIVIDE` on the secondary edge. `ST_DIVIDE` returns to `ST_IDLE` when the quotient is ready. A timeout in any wait or run state, or a zero period, returns to `ST_IDLE` with the error strobe.

Top module: `phase_lag_meter`

## Requirements
- R1: While reset is asserted and right after it, `period_o`, `lag_o` and `phase_o` read zero and `valid_o` and `err_o` are low.
- R2: `period_o` equals the number of clock cycles between two successive reference rising edges. Its minimum is 2.
- R3: `lag_o` equals the number of clock cycles from a reference rising edge that follows the period measurement to the first secondary rising edge after it. Secondary edges seen during the period measurement have no effect.
- R4: A secondary rising edge in the same clock as the reference edge that starts the lag measurement gives `lag_o` = 0.
- R5: `phase_o` equals floor(3600·`lag_o`/`period_o`), in units of 0.1 degree. When the lag is below the period, it is below 3600.
- R6: `valid_o` is a one-cycle pulse. All three result outputs change only in the cycle `valid_o` is high.
- R7: If the timer reaches 2^TW−1 while an edge is still awaited, `err_o` pulses for one cycle and `valid_o` stays low. All three results keep their previous values.
- R8: A measurement cycle starts only on an interval tick, and the first tick comes `INTERVAL` clocks after reset. No result appears earlier.
- R9: A period of exactly 2^TW−1 clocks is measured without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference squared signal, asynchronous |
| sec_in | input | 1 | Secondary squared signal, asynchronous |
| period_o | output | TW | Last measured reference period in clocks |
| lag_o | output | TW | Last measured lag in clocks |
| phase_o | output | AW | Phase in tenths of a degree |
| valid_o | output | 1 | One-cycle strobe: new results published |
| err_o | output | 1 | One-cycle strobe: cycle abandoned |

## Verification
The bench targets the following corners, each with the failure it would expose:
- Coincident edges (zero lag): a design that drops the shared edge would instead report a lag of one full period.
- A lag of one cycle less than the period: this shows an off-by-one in the timer start value.
- The smallest period of two clocks: this catches a timer that starts at zero.
- A period of exactly the timer maximum: a design that checks overflow before the stop edge would raise an error here.
- A period switched above the maximum, and a reference that goes silent: both must produce `err_o` while the old results stay published. A design that writes partial counts would show changed outputs.
- Random period and lag pairs: these check the divider quotient against a bench computation.

// File: rtl/plm_pkg.sv
package plm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_WAIT_PER,
        ST_RUN_PER,
        ST_WAIT_LAG,
        ST_RUN_LAG,
        ST_DIVIDE
    } plm_state_e;

    localparam int PHASE_SCALE = 3600;
endpackage

// File: rtl/plm_edge_sync.sv
module plm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], din};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/plm_interval.sv
module plm_interval #(
    parameter int INTERVAL = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/plm_divider.sv
module plm_divider #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] num,
    input  logic [AW-1:0] den,
    output logic          done,
    output logic [AW-1:0] quot
);
    localparam int SW = $clog2(AW + 1);

    logic [AW:0]   rem;
    logic [AW-1:0] den_q;
    logic [SW-1:0] left;
    logic [AW:0]   shifted;
    logic          fits;

    assign shifted = {rem[AW-1:0], quot[AW-1]};
    assign fits    = (shifted >= {1'b0, den_q});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            quot  <= '0;
            den_q <= '0;
            left  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem   <= '0;
                quot  <= num;
                den_q <= den;
                left  <= SW'(AW);
            end else if (left != '0) begin
                rem  <= fits ? (shifted - {1'b0, den_q}) : shifted;
                quot <= {quot[AW-2:0], fits};
                left <= left - 1'b1;
                done <= (left == SW'(1));
            end
        end
    end
endmodule

// File: rtl/phase_lag_meter.sv
module phase_lag_meter #(
    parameter int TW       = 16,
    parameter int INTERVAL = 62_500_000,
    parameter int SYNC     = 2,
    parameter int AW       = (2 * TW > TW + 12) ? 2 * TW : TW + 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_in,
    input  logic          sec_in,
    output logic [TW-1:0] period_o,
    output logic [TW-1:0] lag_o,
    output logic [AW-1:0] phase_o,
    output logic          valid_o,
    output logic          err_o
);
    import plm_pkg::*;

    localparam logic [TW-1:0] TMAX  = '1;
    localparam logic [AW-1:0] SCALE = AW'(PHASE_SCALE);

    plm_state_e state, nxt;

    logic [1:0]    raw_in, rise;
    logic          ref_rise, sec_rise, tick;
    logic [TW-1:0] timer, per_q, lag_q, lag_cap;
    logic          abort, div_go, div_done;
    logic [AW-1:0] quot, num;

    assign raw_in = {sec_in, ref_in};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        plm_edge_sync #(.STAGES(SYNC)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .rise (rise[g])
        );
    end

    assign ref_rise = rise[0];
    assign sec_rise = rise[1];

    plm_interval #(.INTERVAL(INTERVAL)) u_interval (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    assign lag_cap = (state == ST_RUN_LAG) ? timer : '0;
    assign num     = SCALE * AW'(lag_cap);

    plm_divider #(.AW(AW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(div_go),
        .num  (num),
        .den  (AW'(per_q)),
        .done (div_done),
        .quot (quot)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt    = state;
        abort  = 1'b0;
        div_go = 1'b0;
        unique case (state)
            ST_IDLE:     if (tick) nxt = ST_CLEAR;
            ST_CLEAR:    nxt = ST_WAIT_PER;
            ST_WAIT_PER: begin
                if (ref_rise)           nxt   = ST_RUN_PER;
                else if (timer == TMAX) abort = 1'b1;
            end
            ST_RUN_PER: begin
                if (ref_rise)           nxt   = ST_WAIT_LAG;
                else if (timer == TMAX) abort = 1'b1;
            end
            ST_WAIT_LAG: begin
                if (ref_rise && sec_rise) div_go = 1'b1;
                else if (ref_rise)        nxt    = ST_RUN_LAG;
                else if (timer == TMAX)   abort  = 1'b1;
            end
            ST_RUN_LAG: begin
                if (sec_rise)           div_go = 1'b1;
                else if (timer == TMAX) abort  = 1'b1;
            end
            ST_DIVIDE:   if (div_done) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
        if (div_go) begin
            if (per_q == '0) begin
                div_go = 1'b0;
                abort  = 1'b1;
            end else begin
                nxt = ST_DIVIDE;
            end
        end
        if (abort) nxt = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer    <= '0;
            per_q    <= '0;
            lag_q    <= '0;
            period_o <= '0;
            lag_o    <= '0;
            phase_o  <= '0;
            valid_o  <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= abort;
            case (state)
                ST_CLEAR:                timer <= '0;
                ST_WAIT_PER, ST_WAIT_LAG: timer <= ref_rise ? TW'(1) : timer + 1'b1;
                ST_RUN_PER: begin
                    if (ref_rise) begin
                        per_q <= timer;
                        timer <= '0;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                ST_RUN_LAG:              timer <= timer + 1'b1;
                ST_DIVIDE: begin
                    if (div_done) begin
                        period_o <= per_q;
                        lag_o    <= lag_q;
                        phase_o  <= quot;
                        valid_o  <= 1'b1;
                    end
                end
                default: ;
            endcase
            if (div_go) lag_q <= lag_cap;
        end
    end
endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
    parameter int TW = 16,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] period_o,
    input logic [TW-1:0] lag_o,
    input logic [AW-1:0] phase_o,
    input logic          valid_o,
    input logic          err_o
);
    assert_one_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(period_o) && $stable(lag_o) && $stable(phase_o)));

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));

    assert_hold_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(period_o) && $stable(lag_o) && $stable(phase_o)));

    assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (lag_o < period_o)) |-> (phase_o < AW'(3600)));

    assert_min_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (period_o >= TW'(2)));
endmodule

bind phase_lag_meter plm_checker #(.TW(TW), .AW(AW)) u_plm_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .period_o(period_o),
    .lag_o   (lag_o),
    .phase_o (phase_o),
    .valid_o (valid_o),
    .err_o   (err_o)
);

// File: tb/test_phase_lag_meter.sv
module test_phase_lag_meter;
    localparam int TW       = 10;
    localparam int INTERVAL = 50;
    localparam int AW       = (2 * TW > TW + 12) ? 2 * TW : TW + 12;
    localparam int TMAXV    = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_in, sec_in;
    logic [TW-1:0] period_o, lag_o;
    logic [AW-1:0] phase_o;
    logic          valid_o, err_o;

    int checks = 0;
    int fails  = 0;
    int per_p  = 10;
    int lag_l  = 0;
    int ph     = 0;
    bit ref_en = 1'b1;
    bit restart = 1'b0;

    always #4 clk = ~clk;

    phase_lag_meter #(.TW(TW), .INTERVAL(INTERVAL)) i_phase_lag_meter (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .sec_in(sec_in),
        .period_o(period_o), .lag_o(lag_o), .phase_o(phase_o),
        .valid_o(valid_o), .err_o(err_o)
    );

    // Waveform generator: reference rises at ph==0, secondary rises at ph==L.
    always @(negedge clk) begin
        if (restart) ph = 0;
        else         ph = (ph + 1) % per_p;
        ref_in <= ref_en && (ph < per_p / 2);
        sec_in <= ref_en && (((ph + per_p - lag_l) % per_p) < per_p / 2);
    end

    function automatic longint exp_phase(int p, int l);
        return (longint'(3600) * l) / p;
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_result(output bit got_v, output bit got_e, output int cyc);
        got_v = 0; got_e = 0; cyc = 0;
        while (!got_v && !got_e && cyc < 8000) begin
            @(negedge clk);
            cyc++;
            got_v = valid_o;
            got_e = err_o;
        end
    endtask

    task automatic set_wave(int p, int l, bit en);
        @(negedge clk);
        per_p = p; lag_l = l; ref_en = en; restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic run_vec(int p, int l, bit first);
        bit v, e;
        int cyc;
        rst_n = 1'b0;
        set_wave(p, l, 1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_result(v, e, cyc);
        if (first) check("R8 earliest result cycle >= INTERVAL", (cyc >= INTERVAL), 1);
        check("R2 R3 valid seen", v, 1);
        check("R2 period", period_o, p);
        check((l == 0) ? "R4 coincident lag" : "R3 lag", lag_o, l);
        check("R5 phase", phase_o, exp_phase(p, l));
        @(negedge clk);
        check("R6 valid one-shot", valid_o, 0);
    endtask

    initial begin
        bit v, e;
        int cyc, p, l;
        logic [TW-1:0] hold_p, hold_l;
        logic [AW-1:0] hold_ph;
        void'($urandom(32'd20240611));
        ref_in = 1'b0; sec_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 reset period", period_o, 0);
        check("R1 reset lag", lag_o, 0);
        check("R1 reset phase", phase_o, 0);
        check("R1 reset strobes", {valid_o, err_o}, 0);

        run_vec(10, 3, 1'b1);
        run_vec(2, 0, 1'b0);
        run_vec(2, 1, 1'b0);
        run_vec(10, 0, 1'b0);
        run_vec(10, 9, 1'b0);
        run_vec(360, 90, 1'b0);
        run_vec(TMAXV, 511, 1'b0);   // R9 boundary period
        check("R9 max period reached", period_o, TMAXV);
        run_vec(TMAXV, TMAXV - 1, 1'b0);
        for (int i = 0; i < 14; i++) begin
            p = 3 + int'($urandom() % 398);
            l = int'($urandom() % p);
            run_vec(p, l, 1'b0);
        end

        // R7: period above timer range, no reset between cycles
        run_vec(100, 37, 1'b0);
        hold_p = period_o; hold_l = lag_o; hold_ph = phase_o;
        set_wave(TMAXV + 77, 5, 1'b1);
        wait_result(v, e, cyc);
        check("R7 overflow raises err", e, 1);
        check("R7 overflow no valid", v, 0);
        check("R7 period held", period_o, hold_p);
        check("R7 lag held", lag_o, hold_l);
        check("R7 phase held", phase_o, hold_ph);

        // R7: silent reference times out while waiting
        set_wave(10, 0, 1'b0);
        wait_result(v, e, cyc);
        check("R7 silent input err", e, 1);
        check("R7 silent period held", period_o, hold_p);
        check("R7 silent phase held", phase_o, hold_ph);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule